// File: doc/BRIEF.md
# Nonvolatile Command Sequence Decoder

This block sits beside the host access port of a memory that has a nonvolatile backing copy. It watches every completed host access, each given as an address plus a read/write flag. It recognises two fixed series of six read addresses. One series asks for the nonvolatile copy to be loaded into the working array (recall). The other asks for the working array to be saved into the nonvolatile copy (store). When a series completes, the block raises a one-cycle request toward the transfer controller.

Each series has its own progress counter, and both counters advance in parallel. The two default series share their first five addresses and differ only in the last one. A write, an unexpected read, or any access made while the transfer controller reports busy drops the progress. A store request is also withheld when the supply is not good at the moment the series completes. Data moving through the memory is not handled here.

Top module: `nvcmd_seq_decoder`

## Requirements
- R1: While and after a synchronous active-low reset, `store_req` and `recall_req` are low and no series is in progress.
- R2: Six consecutive read accesses at hex 0000, 1555, 0AAA, 1FFF, 10F0, 0F0E raise `recall_req` on the clock cycle after the sixth read is sampled. No request appears before that.
- R3: Six consecutive read accesses at hex 0000, 1555, 0AAA, 1FFF, 10F0, 0F0F (a parameter) raise `store_req` on the cycle after the sixth read, provided `supply_ok` is high with that read.
- R4: A write access (`acc_is_read` low) never counts as a step and resets both series, even when its address is the one expected next.
- R5: A read at an address other than the expected next one aborts the series. If that address equals the series' first address, it is taken as step one of a new attempt.
- R6: Cycles with `acc_valid` low are not accesses and do not disturb a series in progress.
- R7: A store series that completes while `supply_ok` is low produces no `store_req` and still returns that series to its start. `recall_req` does not depend on `supply_ok`.
- R8: While `busy` is high, accesses are ignored and both series return to their start.
- R9: Each request is a single-cycle pulse. After it fires, that series restarts from step one, so a repeat of only the last address does not fire again.
- R10: Both series are tracked in parallel over the same accesses. A completed recall series raises only `recall_req`, and a completed store series raises only `store_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | A host access completes in this cycle |
| acc_is_read | input | 1 | 1 = read access, 0 = write access |
| acc_addr | input | 13 | Address of the access |
| supply_ok | input | 1 | Supply above the switch threshold |
| busy | input | 1 | Transfer controller busy; accesses are ignored |
| store_req | output | 1 | One-cycle store request pulse |
| recall_req | output | 1 | One-cycle recall request pulse |

## Verification
Both complete series are driven back to back and with idle gaps. This separates progress that counts accesses from progress that counts cycles. Each series is then broken in turn: by a write to the expected address, by a wrong read, by a wrong read equal to the first address, and by an access made while busy. These runs tell a true restart apart from a counter that merely pauses. Store runs with the supply low, followed by a lone final address, show that a withheld request still clears the progress. Repeated completions confirm the single-cycle pulse and the restart after firing.

// File: rtl/nvcmd_pkg.sv
// Package: shared defaults for the command sequence decoder.
// Step 0 of each series sits in the least significant address slot.
package nvcmd_pkg;
    localparam int ADDR_W_DEF  = 13;
    localparam int SEQ_LEN_DEF = 6;
    localparam int CMD_RECALL  = 0;
    localparam int CMD_STORE   = 1;
    localparam int CMD_COUNT   = 2;

    localparam logic [SEQ_LEN_DEF*ADDR_W_DEF-1:0] RECALL_SEQ_DEF =
        {13'h0F0E, 13'h10F0, 13'h1FFF, 13'h0AAA, 13'h1555, 13'h0000};
    localparam logic [SEQ_LEN_DEF*ADDR_W_DEF-1:0] STORE_SEQ_DEF =
        {13'h0F0F, 13'h10F0, 13'h1FFF, 13'h0AAA, 13'h1555, 13'h0000};
endpackage

// File: rtl/nvcmd_step_compare.sv
// Module: nvcmd_step_compare
// Compares an access address with the series entry chosen by the current
// progress index, and with the series' first entry.
// Assumes idx never exceeds STEPS-1; a larger idx matches nothing.
module nvcmd_step_compare #(
    parameter int AW    = 13,
    parameter int STEPS = 6,
    parameter int IW    = 3,
    parameter logic [STEPS*AW-1:0] SEQ = '0
) (
    input  logic [AW-1:0] addr,
    input  logic [IW-1:0] idx,
    output logic          hit_next,
    output logic          hit_first
);
    logic [AW-1:0] expected;

    // Select the address expected at the current step.
    always_comb begin
        expected = '0;
        for (int i = 0; i < STEPS; i++) begin
            if (idx == IW'(i)) expected = SEQ[i*AW +: AW];
        end
    end

    assign hit_next  = (addr == expected) && (idx < IW'(STEPS));
    assign hit_first = (addr == SEQ[AW-1:0]);
endmodule

// File: rtl/nvcmd_seq_tracker.sv
// Module: nvcmd_seq_tracker
// Tracks progress through one fixed series of read addresses and emits a
// registered one-cycle pulse when the last step matches and fire_en is high.
// Assumes acc_* describe at most one completed access per cycle.
module nvcmd_seq_tracker #(
    parameter int AW    = 13,
    parameter int STEPS = 6,
    parameter logic [STEPS*AW-1:0] SEQ = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_valid,
    input  logic          acc_is_read,
    input  logic [AW-1:0] acc_addr,
    input  logic          busy,
    input  logic          fire_en,
    output logic          hit
);
    localparam int IW = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [IW-1:0] LAST_IDX = IW'(STEPS - 1);

    logic [IW-1:0] idx_q;
    logic          hit_next;
    logic          hit_first;

    nvcmd_step_compare #(
        .AW(AW), .STEPS(STEPS), .IW(IW), .SEQ(SEQ)
    ) cmp_i (
        .addr      (acc_addr),
        .idx       (idx_q),
        .hit_next  (hit_next),
        .hit_first (hit_first)
    );

    // Advance, restart or fire on each accepted access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            hit   <= 1'b0;
        end else begin
            hit <= 1'b0;
            if (busy) begin
                idx_q <= '0;
            end else if (acc_valid) begin
                if (!acc_is_read) begin
                    idx_q <= '0;
                end else if (hit_next) begin
                    if (idx_q == LAST_IDX) begin
                        idx_q <= '0;
                        hit   <= fire_en;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end else if (hit_first) begin
                    idx_q <= IW'(1);
                end else begin
                    idx_q <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/nvcmd_seq_decoder.sv
// Module: nvcmd_seq_decoder (top)
// Decodes the recall and store read-address series in parallel and emits
// one-cycle request pulses. Store completion is gated by supply_ok.
// Assumes the two series differ in at least their final address.
module nvcmd_seq_decoder #(
    parameter int AW    = nvcmd_pkg::ADDR_W_DEF,
    parameter int STEPS = nvcmd_pkg::SEQ_LEN_DEF,
    parameter logic [STEPS*AW-1:0] RECALL_SEQ = nvcmd_pkg::RECALL_SEQ_DEF,
    parameter logic [STEPS*AW-1:0] STORE_SEQ  = nvcmd_pkg::STORE_SEQ_DEF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_valid,
    input  logic          acc_is_read,
    input  logic [AW-1:0] acc_addr,
    input  logic          supply_ok,
    input  logic          busy,
    output logic          store_req,
    output logic          recall_req
);
    logic [nvcmd_pkg::CMD_COUNT-1:0] hit_vec;

    for (genvar c = 0; c < nvcmd_pkg::CMD_COUNT; c++) begin : g_cmd
        localparam logic [STEPS*AW-1:0] SEQ_SEL =
            (c == nvcmd_pkg::CMD_STORE) ? STORE_SEQ : RECALL_SEQ;
        logic fire_en;

        // Only the store series depends on a good supply.
        assign fire_en = (c == nvcmd_pkg::CMD_STORE) ? supply_ok : 1'b1;

        nvcmd_seq_tracker #(
            .AW(AW), .STEPS(STEPS), .SEQ(SEQ_SEL)
        ) trk_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .acc_valid   (acc_valid),
            .acc_is_read (acc_is_read),
            .acc_addr    (acc_addr),
            .busy        (busy),
            .fire_en     (fire_en),
            .hit         (hit_vec[c])
        );
    end

    assign recall_req = hit_vec[nvcmd_pkg::CMD_RECALL];
    assign store_req  = hit_vec[nvcmd_pkg::CMD_STORE];
endmodule

// File: rtl/nvcmd_seq_decoder_chk.sv
// Module: nvcmd_seq_decoder_chk
// Port-level temporal checks for nvcmd_seq_decoder, attached by bind.
module nvcmd_seq_decoder_chk #(
    parameter int AW = 13
) (
    input logic          clk,
    input logic          rst_n,
    input logic          acc_valid,
    input logic          acc_is_read,
    input logic [AW-1:0] acc_addr,
    input logic          supply_ok,
    input logic          busy,
    input logic          store_req,
    input logic          recall_req
);
    AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(store_req && recall_req)); // R10
    AST_STORE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        store_req |=> !store_req); // R9
    AST_RECALL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        recall_req |=> !recall_req); // R9
    AST_STORE_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
        store_req |-> $past(supply_ok)); // R7
    AST_REQ_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (store_req || recall_req) |-> $past(acc_valid && acc_is_read)); // R4
    AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> !(store_req || recall_req)); // R8
    AST_ADDR_USED: assert property (@(posedge clk) disable iff (!rst_n)
        (store_req || recall_req) |-> $past(acc_addr) != '0); // R2
endmodule

bind nvcmd_seq_decoder nvcmd_seq_decoder_chk #(.AW(AW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid   (acc_valid),
    .acc_is_read (acc_is_read),
    .acc_addr    (acc_addr),
    .supply_ok   (supply_ok),
    .busy        (busy),
    .store_req   (store_req),
    .recall_req  (recall_req)
);

// File: tb/nvcmd_seq_decoder_tb_top.sv
`timescale 1ns/1ps
module nvcmd_seq_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_is_read = 1'b0;
    logic [12:0] acc_addr = '0;
    logic        supply_ok = 1'b1;
    logic        busy = 1'b0;
    logic        store_req;
    logic        recall_req;

    int n_checks = 0;
    int n_fails  = 0;
    logic obs_s, obs_r;

    logic [12:0] rseq [6] = '{13'h0000, 13'h1555, 13'h0AAA, 13'h1FFF, 13'h10F0, 13'h0F0E};
    logic [12:0] sseq [6] = '{13'h0000, 13'h1555, 13'h0AAA, 13'h1FFF, 13'h10F0, 13'h0F0F};

    always #5 clk = ~clk;

    nvcmd_seq_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_is_read(acc_is_read),
        .acc_addr(acc_addr), .supply_ok(supply_ok), .busy(busy),
        .store_req(store_req), .recall_req(recall_req)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    // One access; called at a negedge, returns at the next negedge with outputs sampled.
    task automatic acc(input logic [12:0] a, input logic rd);
        acc_addr = a; acc_is_read = rd; acc_valid = 1'b1;
        @(negedge clk);
        obs_s = store_req; obs_r = recall_req;
        acc_valid = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
        obs_s = store_req; obs_r = recall_req;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 store_req in reset", store_req, 1'b0);
        chk("R1 recall_req in reset", recall_req, 1'b0);
        rst_n = 1'b1;
        idle();
        chk("R1 store_req after reset", obs_s, 1'b0);
        chk("R1 recall_req after reset", obs_r, 1'b0);
    endtask

    task automatic t_recall();
        for (int i = 0; i < 5; i++) acc(rseq[i], 1'b1);
        chk("R2 no recall before sixth", obs_r, 1'b0);
        acc(rseq[5], 1'b1);
        chk("R2 recall fires", obs_r, 1'b1);
        chk("R10 recall series no store", obs_s, 1'b0);
        idle();
        chk("R9 recall pulse one cycle", obs_r, 1'b0);
    endtask

    task automatic t_store();
        for (int i = 0; i < 6; i++) acc(sseq[i], 1'b1);
        chk("R3 store fires", obs_s, 1'b1);
        chk("R10 store series no recall", obs_r, 1'b0);
        idle();
        chk("R9 store pulse one cycle", obs_s, 1'b0);
    endtask

    task automatic t_gaps();
        for (int i = 0; i < 6; i++) begin
            acc(rseq[i], 1'b1);
            repeat (i + 1) idle();
        end
        chk("R6 idle cycles keep progress (no early pulse)", obs_r, 1'b0);
        for (int i = 0; i < 5; i++) begin acc(sseq[i], 1'b1); idle(); end
        acc(sseq[5], 1'b1);
        chk("R6 store with gaps fires", obs_s, 1'b1);
    endtask

    task automatic t_write_abort();
        for (int i = 0; i < 3; i++) acc(rseq[i], 1'b1);
        acc(rseq[3], 1'b0);
        for (int i = 3; i < 6; i++) acc(rseq[i], 1'b1);
        chk("R4 write aborts recall", obs_r, 1'b0);
        for (int i = 0; i < 5; i++) acc(sseq[i], 1'b1);
        acc(sseq[5], 1'b0);
        acc(sseq[5], 1'b1);
        chk("R4 write on last step aborts store", obs_s, 1'b0);
    endtask

    task automatic t_wrong_abort();
        acc(rseq[0], 1'b1); acc(rseq[1], 1'b1); acc(13'h0123, 1'b1);
        for (int i = 2; i < 6; i++) acc(rseq[i], 1'b1);
        chk("R5 wrong read aborts", obs_r, 1'b0);
        acc(rseq[0], 1'b1); acc(rseq[1], 1'b1);
        for (int i = 0; i < 6; i++) acc(rseq[i], 1'b1);
        chk("R5 first address restarts as step one", obs_r, 1'b1);
    endtask

    task automatic t_supply();
        for (int i = 0; i < 5; i++) acc(sseq[i], 1'b1);
        supply_ok = 1'b0;
        acc(sseq[5], 1'b1);
        chk("R7 low supply blocks store", obs_s, 1'b0);
        supply_ok = 1'b1;
        acc(sseq[5], 1'b1);
        chk("R7 store progress cleared after blocked fire", obs_s, 1'b0);
        supply_ok = 1'b0;
        for (int i = 0; i < 6; i++) acc(rseq[i], 1'b1);
        chk("R7 recall ignores supply", obs_r, 1'b1);
        supply_ok = 1'b1;
    endtask

    task automatic t_busy();
        for (int i = 0; i < 3; i++) acc(rseq[i], 1'b1);
        busy = 1'b1;
        acc(rseq[3], 1'b1);
        busy = 1'b0;
        for (int i = 3; i < 6; i++) acc(rseq[i], 1'b1);
        chk("R8 busy resets progress", obs_r, 1'b0);
        busy = 1'b1;
        for (int i = 0; i < 6; i++) acc(sseq[i], 1'b1);
        chk("R8 series during busy ignored", obs_s, 1'b0);
        busy = 1'b0;
        idle();
        chk("R8 no late store after busy", obs_s, 1'b0);
    endtask

    task automatic t_repeat();
        for (int i = 0; i < 6; i++) acc(rseq[i], 1'b1);
        chk("R9 first repeat fires", obs_r, 1'b1);
        acc(rseq[5], 1'b1);
        chk("R9 lone last address after fire", obs_r, 1'b0);
        for (int i = 0; i < 6; i++) acc(rseq[i], 1'b1);
        chk("R9 second full series fires", obs_r, 1'b1);
        for (int i = 0; i < 6; i++) acc(rseq[i], 1'b1);
        chk("R9 back-to-back series fires", obs_r, 1'b1);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_recall();
        t_store();
        t_gaps();
        t_write_abort();
        t_wrong_abort();
        t_supply();
        t_busy();
        t_repeat();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        #1_000_000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule